// File: doc/BRIEF.md
# Packed SIMD Issue-State Controller

This block sits at the issue stage of a processor whose packed 64-bit SIMD extension shares its architectural state with the floating-point unit. Each cycle it accepts one decoded-instruction record. The record carries a valid flag, a SIMD-class flag, an empty-state flag, a memory-operand flag and five prefix flags. The block also reads a floating-point emulation control bit. It decides whether the instruction faults with an invalid-opcode exception or issues. It keeps the shared 16-bit floating-point tag word, with 2 bits for each of the 8 register slots. It also reports which of the address-affecting prefixes apply to address generation.

An instruction that issues overwrites the whole tag word. An ordinary packed instruction writes the all-zeros Valid code into every slot. The empty-state instruction writes the all-ones Empty code into every slot. Some prefixes are ignored and some are qualified by the kind of operand. A lock prefix faults, and so does the emulation bit. A faulting instruction leaves all state untouched.

All outputs are registered. The response to a record presented before a rising edge appears just after that edge. It stays for one cycle, and all outputs of one record appear together.

Top module: `simd_issue_ctl`

## Requirements
- R1: After reset the tag word is 16'hFFFF (every slot Empty, code 2'b11), and `fault_o`, `issue_o`, `agu_asize_o` and `agu_seg_o` are all 0.
- R2: A valid record with `rec_simd_i`=1, no lock, `fp_emul_i`=0 and `rec_empty_i`=0 sets the tag word to 16'h0000 (every slot Valid, code 2'b00) and raises `issue_o` for one cycle.
- R3: A valid record with `rec_empty_i`=1, no lock and `fp_emul_i`=0 sets the tag word to 16'hFFFF and raises `issue_o`. An empty-state record counts as a SIMD-class instruction whatever `rec_simd_i` is.
- R4: A valid SIMD-class record with `pfx_lock_i`=1 raises `fault_o`, keeps `issue_o` at 0 and leaves the tag word unchanged.
- R5: When `fp_emul_i`=1, every valid SIMD-class record raises `fault_o`, keeps `issue_o` at 0 and leaves the tag word unchanged.
- R6: A record that has both a lock prefix and `fp_emul_i`=1 produces exactly one fault: `fault_o` is high in one cycle only, as long as the next record does not fault.
- R7: `pfx_opsize_i` and `pfx_rep_i` have no effect. Outputs and tag word are the same as for the record without them.
- R8: For an issuing record, `agu_asize_o` follows `pfx_asize_i` and `agu_seg_o` follows `pfx_seg_i` only when `rec_mem_i`=1. Otherwise both are 0.
- R9: A valid record with `rec_simd_i`=0 and `rec_empty_i`=0 changes no tag bit and raises neither `fault_o`, `issue_o` nor an address-generation output, whatever its prefixes and `fp_emul_i`.
- R10: A record with `rec_valid_i`=0 has no effect on any output or on the tag word.
- R11: `fault_o` falls back to 0 in the cycle after a faulting record when the following record does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid_i | input | 1 | Record present this cycle |
| rec_simd_i | input | 1 | Record is a packed SIMD instruction |
| rec_empty_i | input | 1 | Record is the empty-state instruction |
| rec_mem_i | input | 1 | Record has a memory operand |
| pfx_lock_i | input | 1 | Lock prefix present |
| pfx_opsize_i | input | 1 | Operand-size prefix present |
| pfx_asize_i | input | 1 | Address-size prefix present |
| pfx_seg_i | input | 1 | Segment-override prefix present |
| pfx_rep_i | input | 1 | Repeat prefix present |
| fp_emul_i | input | 1 | Floating-point emulation control bit |
| tag_word_o | output | 16 | Shared floating-point tag word |
| fault_o | output | 1 | Invalid-opcode exception pulse |
| issue_o | output | 1 | Record issued (did not fault) |
| agu_asize_o | output | 1 | Address-size prefix applies to address generation |
| agu_seg_o | output | 1 | Segment override applies to address generation |

## Verification
Two functions can meet in one cycle: a fault and a tag-word overwrite. A record can be the empty-state instruction and carry a lock prefix or arrive with emulation set. It can also carry both fault causes at once. The bench first puts the tag word at all-Valid. It then presents such records and checks two things: the tag word stays at 16'h0000, and exactly one fault pulse appears with no issue. Non-SIMD records with the same prefixes are checked to leave both the tag word and the fault output alone.

// File: rtl/simd_issue_pkg.sv
package simd_issue_pkg;

   typedef struct packed {
      logic valid;
      logic simd;
      logic empty;
      logic mem;
      logic lock;
      logic opsize;
      logic asize;
      logic seg;
      logic rep;
   } issue_rec_t;

   typedef struct packed {
      logic fault;
      logic issue;
      logic set_empty;
      logic agu_asize;
      logic agu_seg;
   } issue_dec_t;

endpackage

// File: rtl/simd_prefix_dec.sv
module simd_prefix_dec
   import simd_issue_pkg::*;
#(
   parameter bit EMPTY_IS_SIMD = 1'b1
) (
   input  issue_rec_t rec_i,
   input  logic       emul_i,
   output issue_dec_t dec_o
);
   logic simd_class;
   logic fault_cause;

   generate
      if (EMPTY_IS_SIMD) begin : g_empty_simd
         assign simd_class = rec_i.simd | rec_i.empty;
      end else begin : g_simd_only
         assign simd_class = rec_i.simd;
      end
   endgenerate

   // Operand-size and repeat prefixes are deliberately not read.
   assign fault_cause = rec_i.lock | emul_i;

   always_comb begin
      dec_o           = '0;
      dec_o.fault     = rec_i.valid & simd_class & fault_cause;
      dec_o.issue     = rec_i.valid & simd_class & ~fault_cause;
      dec_o.set_empty = rec_i.empty;
      dec_o.agu_asize = rec_i.valid & simd_class & ~fault_cause & rec_i.mem & rec_i.asize;
      dec_o.agu_seg   = rec_i.valid & simd_class & ~fault_cause & rec_i.mem & rec_i.seg;
   end

   always_comb begin
      assert_fault_xor_issue_R4: assert (!(dec_o.fault && dec_o.issue));
   end

endmodule

// File: rtl/simd_tag_word.sv
module simd_tag_word #(
   parameter int unsigned NUM_SLOTS  = 8,
   parameter int unsigned TAG_BITS   = 2,
   parameter logic [TAG_BITS-1:0] VALID_CODE = '0,
   parameter logic [TAG_BITS-1:0] EMPTY_CODE = '1,
   localparam int unsigned TAG_W = NUM_SLOTS * TAG_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic             set_empty_i,
   output logic [TAG_W-1:0] tag_o
);

   generate
      if (NUM_SLOTS < 1) begin : g_bad_slots
         $error("simd_tag_word: NUM_SLOTS must be at least 1");
      end
      if (TAG_BITS < 1) begin : g_bad_bits
         $error("simd_tag_word: TAG_BITS must be at least 1");
      end
      if (VALID_CODE == EMPTY_CODE) begin : g_bad_codes
         $error("simd_tag_word: VALID_CODE and EMPTY_CODE must differ");
      end
   endgenerate

   logic [TAG_BITS-1:0] wr_code;
   assign wr_code = set_empty_i ? EMPTY_CODE : VALID_CODE;

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic [TAG_BITS-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       slot_q <= EMPTY_CODE;
            else if (wr_en_i) slot_q <= wr_code;
         end
         assign tag_o[s*TAG_BITS +: TAG_BITS] = slot_q;
      end
   endgenerate

   assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en_i) |-> $stable(tag_o));

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !set_empty_i) |=> (tag_o == {NUM_SLOTS{VALID_CODE}}));

   assert_empty_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && set_empty_i) |=> (tag_o == {NUM_SLOTS{EMPTY_CODE}}));

endmodule

// File: rtl/simd_issue_ctl.sv
module simd_issue_ctl
   import simd_issue_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned TAG_BITS  = 2,
   parameter bit EMPTY_IS_SIMD      = 1'b1,
   localparam int unsigned TAG_W    = NUM_SLOTS * TAG_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rec_valid_i,
   input  logic             rec_simd_i,
   input  logic             rec_empty_i,
   input  logic             rec_mem_i,
   input  logic             pfx_lock_i,
   input  logic             pfx_opsize_i,
   input  logic             pfx_asize_i,
   input  logic             pfx_seg_i,
   input  logic             pfx_rep_i,
   input  logic             fp_emul_i,
   output logic [TAG_W-1:0] tag_word_o,
   output logic             fault_o,
   output logic             issue_o,
   output logic             agu_asize_o,
   output logic             agu_seg_o
);

   issue_rec_t rec;
   issue_dec_t dec;

   always_comb begin
      rec        = '0;
      rec.valid  = rec_valid_i;
      rec.simd   = rec_simd_i;
      rec.empty  = rec_empty_i;
      rec.mem    = rec_mem_i;
      rec.lock   = pfx_lock_i;
      rec.opsize = pfx_opsize_i;
      rec.asize  = pfx_asize_i;
      rec.seg    = pfx_seg_i;
      rec.rep    = pfx_rep_i;
   end

   simd_prefix_dec #(
      .EMPTY_IS_SIMD (EMPTY_IS_SIMD)
   ) u_dec (
      .rec_i  (rec),
      .emul_i (fp_emul_i),
      .dec_o  (dec)
   );

   simd_tag_word #(
      .NUM_SLOTS (NUM_SLOTS),
      .TAG_BITS  (TAG_BITS)
   ) u_tag (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (dec.issue),
      .set_empty_i (dec.set_empty),
      .tag_o       (tag_word_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_o     <= 1'b0;
         issue_o     <= 1'b0;
         agu_asize_o <= 1'b0;
         agu_seg_o   <= 1'b0;
      end else begin
         fault_o     <= dec.fault;
         issue_o     <= dec.issue;
         agu_asize_o <= dec.agu_asize;
         agu_seg_o   <= dec.agu_seg;
      end
   end

   assert_fault_keeps_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> $stable(tag_word_o));

   assert_single_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_o && issue_o));

   assert_agu_needs_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (agu_asize_o || agu_seg_o) |-> issue_o);

   assert_issue_uniform_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_o |-> (tag_word_o == '0 || tag_word_o == '1));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rec_valid_i) |-> (!fault_o && !issue_o && $stable(tag_word_o)));

endmodule

// File: tb/test_simd_issue_ctl.sv
module test_simd_issue_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        v = 0, simd = 0, emp = 0, mem = 0;
   logic        lck = 0, opsz = 0, asz = 0, seg = 0, rep = 0, emu = 0;
   logic [15:0] tag;
   logic        fault, issue, agu_a, agu_s;
   int          n_chk = 0, n_fail = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   simd_issue_ctl i_simd_issue_ctl (
      .clk(clk), .rst_n(rst_n),
      .rec_valid_i(v), .rec_simd_i(simd), .rec_empty_i(emp), .rec_mem_i(mem),
      .pfx_lock_i(lck), .pfx_opsize_i(opsz), .pfx_asize_i(asz), .pfx_seg_i(seg),
      .pfx_rep_i(rep), .fp_emul_i(emu),
      .tag_word_o(tag), .fault_o(fault), .issue_o(issue),
      .agu_asize_o(agu_a), .agu_seg_o(agu_s)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Present one record, wait for the edge that registers it, sample after it.
   task automatic send(input logic i_v, i_simd, i_emp, i_mem, i_lck, i_opsz,
                       input logic i_asz, i_seg, i_rep, i_emu);
      v = i_v; simd = i_simd; emp = i_emp; mem = i_mem; lck = i_lck;
      opsz = i_opsz; asz = i_asz; seg = i_seg; rep = i_rep; emu = i_emu;
      @(posedge clk); #2;
      v = 0; simd = 0; emp = 0; mem = 0; lck = 0;
      opsz = 0; asz = 0; seg = 0; rep = 0; emu = 0;
   endtask

   task automatic idle_cycle();
      @(posedge clk); #2;
   endtask

   task automatic t_reset();
      check("R1 tag", tag, 32'hFFFF);
      check("R1 outs", {fault, issue, agu_a, agu_s}, 0);
   endtask

   task automatic t_plain_simd();
      send(1,1,0,0, 0,0,0,0,0, 0);
      check("R2 tag", tag, 32'h0000);
      check("R2 issue/fault", {issue, fault}, 2'b10);
      idle_cycle();
      check("R2 issue one cycle", issue, 0);
   endtask

   task automatic t_empty_state();
      send(1,0,1,0, 0,0,0,0,0, 0);
      check("R3 tag", tag, 32'hFFFF);
      check("R3 issue", {issue, fault}, 2'b10);
      send(1,1,0,0, 0,0,0,0,0, 0);
      check("R3 back to valid", tag, 32'h0000);
   endtask

   task automatic t_lock();
      send(1,1,0,0, 0,0,0,0,0, 0);
      send(1,1,0,1, 1,0,1,1,0, 0);
      check("R4 fault", {fault, issue}, 2'b10);
      check("R4 tag kept", tag, 32'h0000);
      check("R4 no agu", {agu_a, agu_s}, 0);
      idle_cycle();
      check("R11 fault drops", fault, 0);
      send(1,0,1,0, 1,0,0,0,0, 0);
      check("R4 locked empty-state fault", {fault, issue}, 2'b10);
      check("R4 locked empty-state tag kept", tag, 32'h0000);
   endtask

   task automatic t_emulation();
      send(1,1,0,0, 0,0,0,0,0, 0);
      send(1,1,0,0, 0,0,0,0,0, 1);
      check("R5 fault", {fault, issue}, 2'b10);
      check("R5 tag kept", tag, 32'h0000);
      send(1,0,1,0, 0,0,0,0,0, 1);
      check("R5 empty-state fault", {fault, issue}, 2'b10);
      check("R5 empty-state tag kept", tag, 32'h0000);
   endtask

   task automatic t_both_causes();
      send(1,1,0,0, 0,0,0,0,0, 0);
      send(1,0,1,0, 1,0,0,0,0, 1);
      check("R6 one fault", {fault, issue}, 2'b10);
      check("R6 tag kept", tag, 32'h0000);
      idle_cycle();
      check("R6 single pulse", fault, 0);
      check("R11 no later fault", fault, 0);
   endtask

   task automatic t_ignored_prefixes();
      send(1,0,1,0, 0,0,0,0,0, 0);
      send(1,1,0,0, 0,1,0,0,1, 0);
      check("R7 tag", tag, 32'h0000);
      check("R7 outs reg", {fault, issue, agu_a, agu_s}, 4'b0100);
      send(1,1,0,1, 0,1,0,0,1, 0);
      check("R7 outs mem", {fault, issue, agu_a, agu_s}, 4'b0100);
   endtask

   task automatic t_agu();
      send(1,1,0,1, 0,0,1,1,0, 0);
      check("R8 mem both", {agu_a, agu_s}, 2'b11);
      send(1,1,0,0, 0,0,1,1,0, 0);
      check("R8 reg ignored", {agu_a, agu_s, issue}, 3'b001);
      send(1,1,0,1, 0,0,1,0,0, 0);
      check("R8 mem asize only", {agu_a, agu_s}, 2'b10);
      send(1,1,0,1, 0,0,0,1,0, 0);
      check("R8 mem seg only", {agu_a, agu_s}, 2'b01);
   endtask

   task automatic t_non_simd();
      send(1,1,0,0, 0,0,0,0,0, 0);
      send(1,0,0,1, 1,1,1,1,1, 0);
      check("R9 tag kept", tag, 32'h0000);
      check("R9 outs", {fault, issue, agu_a, agu_s}, 0);
      send(1,0,0,0, 0,0,0,0,0, 1);
      check("R9 emu no fault", {fault, issue}, 0);
      check("R9 tag kept emu", tag, 32'h0000);
   endtask

   task automatic t_invalid();
      send(0,1,0,1, 1,0,1,1,0, 1);
      check("R10 outs", {fault, issue, agu_a, agu_s}, 0);
      send(0,0,1,0, 0,0,0,0,0, 0);
      check("R10 tag kept", tag, 32'h0000);
      check("R10 no issue", issue, 0);
   endtask

   initial begin
      #23;
      t_reset();
      rst_n = 1'b1;
      @(posedge clk); #2;
      t_reset();
      t_plain_simd();
      t_empty_state();
      t_lock();
      t_emulation();
      t_both_causes();
      t_ignored_prefixes();
      t_agu();
      t_non_simd();
      t_invalid();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule